// File: doc/BRIEF.md
# Staged UART Line-Control Register Bank

This block is the bus-facing control store of a UART. It keeps a 23-bit line-control word. The top 7 bits hold the frame format fields. The lower 16 bits hold the baud divisor. Software reaches the word through three byte-wide registers. Writes to the divisor bytes land in holding registers and do not reach the transmitter or receiver. A write to the format byte commits the format bits and both held divisor bytes into the live word at one clock edge. The serial logic therefore never sees a half-updated divisor or format.

The block also keeps a framing-error flag in a receive status register. When the FIFO is off, the flag is sticky: it is set by any received character whose stop bit reads 0. When the FIFO is on, the flag follows the error tag of the character at the head of the receive FIFO. Any write to the status register clears the flag. The live word is decoded into ready-made controls: data bits per frame, parity enable and sense, two stop bits, FIFO enable and line break.

The write port has one byte-enable per register, so a single cycle may write any mix of the registers. Reads are combinational through a 2-bit register index. The register indices are 0 for status, 1 for divisor low, 2 for divisor high and 3 for format.

Top module: `uart_linectl_bank`

## Requirements
- R1: After reset all registers are zero. Every read returns 0, `baud_div` is 0, `data_bits` is 5, and every control flag and `frame_err` is 0.
- R2: A write to register 1 or 2 without a write to register 3 updates only the holding register. A read of register 1 or 2 returns the holding value. `baud_div` and all format controls keep their values.
- R3: A write to register 3 sets the live word to {written byte bits 6:0, holding register 2, holding register 1} at that clock edge. `baud_div` is {holding 2, holding 1}.
- R4: Writing register 1 then register 2, or register 2 then register 1, before the register 3 write gives the same committed word.
- R5: A write to only one divisor byte followed by a register 3 write changes only that byte of `baud_div`. The other byte keeps its earlier held value.
- R6: When register 3 is written in the same cycle as register 1 and/or 2, the commit uses the bytes written in that cycle.
- R7: Format byte fields are: bit 0 break (`brk_en`), bit 1 parity enable, bit 2 even parity, bit 3 two stop bits, bit 4 FIFO enable, and bits 6:5 word length. Bit 7 is ignored and reads as 0 in register 3. Register 0 reads as {7'b0, frame_err}.
- R8: `data_bits` equals 5 plus the word-length field: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R9: With the FIFO disabled, a completed character (`rx_done`) with `rx_stop_bit` = 0 sets `frame_err` at the next edge. A character with stop bit 1 leaves the flag as it was.
- R10: Any write to register 0 clears `frame_err` at the next edge. A set event in the same cycle takes priority and leaves the flag at 1.
- R11: With the FIFO enabled, `frame_err` loads `rx_head_ferr` whenever `rx_head_adv` pulses, and `rx_done` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_be | input | 4 | Per-register write enable; bit i writes register i |
| wdata | input | 32 | Write data; byte i goes to register i |
| rd_addr | input | 2 | Register index for reads |
| rdata | output | 8 | Read data of the selected register |
| rx_done | input | 1 | Receiver finished a character |
| rx_stop_bit | input | 1 | Stop bit sampled for that character |
| rx_head_adv | input | 1 | Receive FIFO head changed |
| rx_head_ferr | input | 1 | Framing-error tag of the new FIFO head |
| baud_div | output | 16 | Committed baud divisor |
| data_bits | output | 4 | Data bits per frame (5 to 8) |
| parity_en | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity selected |
| two_stop | output | 1 | Two stop bits |
| fifo_en | output | 1 | FIFO mode enabled |
| brk_en | output | 1 | Force line break |
| frame_err | output | 1 | Framing-error status flag |

## Verification
The hardest case to reach from the ports is a commit in the same cycle as a divisor-byte write. A sequential bus model never produces it, because it issues one register access per cycle. The bench drives several byte enables together so that a format write meets fresh low and mid bytes at one edge. It also stages stale held values first, so that a commit taking the wrong copy shows up. The status-clear race is reached the same way: a status write and a bad stop bit are driven in one cycle.

// File: rtl/ulc_pkg.sv
package ulc_pkg;
   localparam int NUM_REGS = 4;
   localparam int IDX_STAT = 0;
   localparam int IDX_LO   = 1;
   localparam int IDX_MID  = 2;
   localparam int IDX_HI   = 3;

   localparam int POS_BRK  = 0;
   localparam int POS_PEN  = 1;
   localparam int POS_EVEN = 2;
   localparam int POS_STP2 = 3;
   localparam int POS_FIFO = 4;
   localparam int POS_WLEN = 5;
   localparam int MIN_HI_W = 7;

   typedef struct packed {
      logic [3:0] data_bits;
      logic       parity_en;
      logic       parity_even;
      logic       two_stop;
      logic       fifo_en;
      logic       brk_en;
   } line_ctl_t;
endpackage

// File: rtl/ulc_shadow.sv
module ulc_shadow #(
   parameter int LANE_W = 8,
   parameter int HIGH_W = 7,
   localparam int NREG   = ulc_pkg::NUM_REGS,
   localparam int WORD_W = HIGH_W + 2 * LANE_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NREG-1:0]        wr_be,
   input  logic [NREG*LANE_W-1:0] wdata,
   output logic [LANE_W-1:0]      hold_lo,
   output logic [LANE_W-1:0]      hold_mid,
   output logic [WORD_W-1:0]      live_word
);
   logic [LANE_W-1:0] hold_q   [2];
   logic [LANE_W-1:0] hold_nxt [2];

   // one holding register per divisor byte
   for (genvar g = 0; g < 2; g++) begin : g_hold
      localparam int LANE = ulc_pkg::IDX_LO + g;
      always_comb begin
         hold_nxt[g] = wr_be[LANE] ? wdata[LANE*LANE_W +: LANE_W] : hold_q[g];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hold_q[g] <= '0;
         else        hold_q[g] <= hold_nxt[g];
      end
   end

   assign hold_lo  = hold_q[0];
   assign hold_mid = hold_q[1];

   // commit picks up same-cycle divisor writes through hold_nxt
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_word <= '0;
      end else if (wr_be[ulc_pkg::IDX_HI]) begin
         live_word <= {wdata[ulc_pkg::IDX_HI*LANE_W +: HIGH_W], hold_nxt[1], hold_nxt[0]};
      end
   end
endmodule

// File: rtl/ulc_decode.sv
module ulc_decode #(
   parameter int HIGH_W = 7
) (
   input  logic [HIGH_W-1:0]     fmt,
   output ulc_pkg::line_ctl_t    ctl
);
   import ulc_pkg::*;
   logic [1:0] wlen;
   assign wlen = fmt[POS_WLEN +: 2];

   always_comb begin
      ctl.data_bits   = 4'd5 + {2'b00, wlen};
      ctl.parity_en   = fmt[POS_PEN];
      ctl.parity_even = fmt[POS_EVEN];
      ctl.two_stop    = fmt[POS_STP2];
      ctl.fifo_en     = fmt[POS_FIFO];
      ctl.brk_en      = fmt[POS_BRK];
   end

   if (HIGH_W > MIN_HI_W) begin : g_wide
      logic [HIGH_W-MIN_HI_W-1:0] unused_fmt_hi;
      assign unused_fmt_hi = fmt[HIGH_W-1:MIN_HI_W];
   end
endmodule

// File: rtl/ulc_rxstat.sv
module ulc_rxstat (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_mode,
   input  logic stat_wr,
   input  logic rx_done,
   input  logic rx_stop_bit,
   input  logic rx_head_adv,
   input  logic rx_head_ferr,
   output logic ferr
);
   logic direct_set;
   assign direct_set = !fifo_mode && rx_done && !rx_stop_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ferr <= 1'b0;
      else if (fifo_mode && rx_head_adv) ferr <= rx_head_ferr;
      else if (direct_set)               ferr <= 1'b1;
      else if (stat_wr)                  ferr <= 1'b0;
   end
endmodule

// File: rtl/uart_linectl_bank.sv
module uart_linectl_bank #(
   parameter int LANE_W = 8,
   parameter int HIGH_W = 7,
   localparam int NREG   = ulc_pkg::NUM_REGS,
   localparam int AW     = $clog2(NREG),
   localparam int DIV_W  = 2 * LANE_W,
   localparam int WORD_W = HIGH_W + DIV_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NREG-1:0]        wr_be,
   input  logic [NREG*LANE_W-1:0] wdata,
   input  logic [AW-1:0]          rd_addr,
   output logic [LANE_W-1:0]      rdata,
   input  logic                   rx_done,
   input  logic                   rx_stop_bit,
   input  logic                   rx_head_adv,
   input  logic                   rx_head_ferr,
   output logic [DIV_W-1:0]       baud_div,
   output logic [3:0]             data_bits,
   output logic                   parity_en,
   output logic                   parity_even,
   output logic                   two_stop,
   output logic                   fifo_en,
   output logic                   brk_en,
   output logic                   frame_err
);
   import ulc_pkg::*;

   if (HIGH_W < MIN_HI_W) begin : g_chk_hi
      $error("HIGH_W must hold the full format field");
   end
   if (HIGH_W > LANE_W) begin : g_chk_lane
      $error("HIGH_W must fit in one register lane");
   end

   logic [LANE_W-1:0] hold_lo, hold_mid;
   logic [WORD_W-1:0] live_word;
   line_ctl_t         ctl;
   logic [LANE_W-1:0] unused_stat_data;

   assign unused_stat_data = wdata[IDX_STAT*LANE_W +: LANE_W];

   ulc_shadow #(.LANE_W(LANE_W), .HIGH_W(HIGH_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .wr_be(wr_be), .wdata(wdata),
      .hold_lo(hold_lo), .hold_mid(hold_mid), .live_word(live_word)
   );

   ulc_decode #(.HIGH_W(HIGH_W)) u_decode (
      .fmt(live_word[WORD_W-1:DIV_W]), .ctl(ctl)
   );

   ulc_rxstat u_rxstat (
      .clk(clk), .rst_n(rst_n), .fifo_mode(ctl.fifo_en),
      .stat_wr(wr_be[IDX_STAT]), .rx_done(rx_done), .rx_stop_bit(rx_stop_bit),
      .rx_head_adv(rx_head_adv), .rx_head_ferr(rx_head_ferr), .ferr(frame_err)
   );

   if (HIGH_W < LANE_W) begin : g_hi_pad
      logic [LANE_W-HIGH_W-1:0] unused_hi_wdata;
      assign unused_hi_wdata = wdata[IDX_HI*LANE_W+HIGH_W +: LANE_W-HIGH_W];
   end

   // reads are combinational; the format register keeps only MIN_HI_W live bits
   always_comb begin
      rdata = '0;
      case (rd_addr)
         AW'(IDX_STAT): rdata[0] = frame_err;
         AW'(IDX_LO):   rdata = hold_lo;
         AW'(IDX_MID):  rdata = hold_mid;
         default:       rdata[MIN_HI_W-1:0] = live_word[DIV_W +: MIN_HI_W];
      endcase
   end

   assign baud_div    = live_word[DIV_W-1:0];
   assign data_bits   = ctl.data_bits;
   assign parity_en   = ctl.parity_en;
   assign parity_even = ctl.parity_even;
   assign two_stop    = ctl.two_stop;
   assign fifo_en     = ctl.fifo_en;
   assign brk_en      = ctl.brk_en;
endmodule

// File: rtl/ulc_checker.sv
module ulc_checker #(
   parameter int LANE_W = 8,
   parameter int HIGH_W = 7,
   localparam int WORD_W = HIGH_W + 2 * LANE_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic [3:0]          wr_be,
   input logic [4*LANE_W-1:0] wdata,
   input logic [LANE_W-1:0]   hold_lo,
   input logic [LANE_W-1:0]   hold_mid,
   input logic [WORD_W-1:0]   live_word,
   input logic [3:0]          data_bits,
   input logic                fifo_en,
   input logic                rx_done,
   input logic                rx_stop_bit,
   input logic                rx_head_adv,
   input logic                rx_head_ferr,
   input logic                frame_err
);
   // R2: without a format write the live word holds
   assert_live_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_be[3] |=> $stable(live_word));

   // R3 / R6: the commit takes the freshest divisor bytes
   assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_be[3] |=> live_word == {$past(wdata[3*LANE_W +: HIGH_W]),
                                 ($past(wr_be[2]) ? $past(wdata[2*LANE_W +: LANE_W]) : $past(hold_mid)),
                                 ($past(wr_be[1]) ? $past(wdata[LANE_W +: LANE_W]) : $past(hold_lo))});

   // R8: data bits stay within 5..8
   assert_wlen_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      data_bits >= 4'd5 && data_bits <= 4'd8);

   // R9: bad stop bit in direct mode sets the flag
   assert_fe_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en && rx_done && !rx_stop_bit |=> frame_err);

   // R10: status write with no competing event clears
   assert_fe_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_be[0] && !rx_done && !rx_head_adv |=> !frame_err);

   // R11: FIFO mode follows the head tag
   assert_fifo_head_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && rx_head_adv |=> frame_err == $past(rx_head_ferr));
endmodule

bind uart_linectl_bank ulc_checker #(.LANE_W(LANE_W), .HIGH_W(HIGH_W)) u_ulc_checker (
   .clk(clk), .rst_n(rst_n), .wr_be(wr_be), .wdata(wdata),
   .hold_lo(hold_lo), .hold_mid(hold_mid), .live_word(live_word),
   .data_bits(data_bits), .fifo_en(fifo_en), .rx_done(rx_done),
   .rx_stop_bit(rx_stop_bit), .rx_head_adv(rx_head_adv),
   .rx_head_ferr(rx_head_ferr), .frame_err(frame_err)
);

// File: tb/uart_linectl_bank_bench.sv
`timescale 1ns/1ps
module uart_linectl_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  wr_be = '0;
   logic [31:0] wdata = '0;
   logic [1:0]  rd_addr = '0;
   logic [7:0]  rdata;
   logic        rx_done = 1'b0, rx_stop_bit = 1'b1, rx_head_adv = 1'b0, rx_head_ferr = 1'b0;
   logic [15:0] baud_div;
   logic [3:0]  data_bits;
   logic        parity_en, parity_even, two_stop, fifo_en, brk_en, frame_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_linectl_bank u_uart_linectl_bank (
      .clk(clk), .rst_n(rst_n), .wr_be(wr_be), .wdata(wdata), .rd_addr(rd_addr),
      .rdata(rdata), .rx_done(rx_done), .rx_stop_bit(rx_stop_bit),
      .rx_head_adv(rx_head_adv), .rx_head_ferr(rx_head_ferr), .baud_div(baud_div),
      .data_bits(data_bits), .parity_en(parity_en), .parity_even(parity_even),
      .two_stop(two_stop), .fifo_en(fifo_en), .brk_en(brk_en), .frame_err(frame_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive one cycle at a falling edge; results are visible at the next falling edge
   task automatic wr(input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      wr_be = be; wdata = d;
      @(negedge clk);
      wr_be = '0; wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      rd_addr = a;
      #1;
      v = rdata;
   endtask

   task automatic check_fmt(input string tag, input logic [7:0] h);
      check({tag, " R8 data_bits"}, 32'(data_bits), 32'(5 + h[6:5]));
      check({tag, " R7 flags"}, {27'b0, brk_en, parity_en, parity_even, two_stop, fifo_en},
            {27'b0, h[0], h[1], h[2], h[3], h[4]});
   endtask

   initial begin
      logic [7:0] v;
      logic [15:0] prev_div;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 baud", 32'(baud_div), 0);
      check("R1 bits", 32'(data_bits), 5);
      check("R1 flags", {26'b0, brk_en, parity_en, parity_even, two_stop, fifo_en, frame_err}, 0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check("R1 read", 32'(v), 0);
      end

      // sweep every format byte with derived divisor bytes
      for (int h = 0; h < 256; h++) begin
         logic [7:0] lo, mi;
         lo = 8'(h) ^ 8'h5A;
         mi = ~8'(h);
         prev_div = baud_div;
         if (h % 2 == 0) begin
            wr(4'b0010, {16'b0, lo, 8'b0});   // R4 order: low first
            wr(4'b0100, {8'b0, mi, 16'b0});
         end else begin
            wr(4'b0100, {8'b0, mi, 16'b0});   // R4 order: mid first
            wr(4'b0010, {16'b0, lo, 8'b0});
         end
         check("R2 divisor not live", 32'(baud_div), 32'(prev_div));
         rd(2'd1, v); check("R2 read low hold", 32'(v), 32'(lo));
         rd(2'd2, v); check("R2 read mid hold", 32'(v), 32'(mi));
         wr(4'b1000, {8'(h), 24'b0});
         check("R3 R4 commit", 32'(baud_div), 32'({mi, lo}));
         check_fmt("R3", 8'(h));
         rd(2'd3, v); check("R7 fmt read bit7 zero", 32'(v), 32'(h & 8'h7F));
      end

      // R5 partial update of only the low byte
      wr(4'b0010, 32'h0000_3C00);
      wr(4'b1000, 32'h0300_0000);
      check("R5 low only", 32'(baud_div), 32'h003C);          // mid held ~8'hFF = 00
      wr(4'b0100, 32'h00A5_0000);
      wr(4'b1000, 32'h6000_0000);
      check("R5 mid only", 32'(baud_div), 32'hA53C);
      check_fmt("R5", 8'h60);

      // R6 same-cycle writes against stale holding values
      wr(4'b0110, 32'h0011_2200);
      wr(4'b1110, 32'h4577_8800);
      check("R6 both fresh", 32'(baud_div), 32'h7788);
      check_fmt("R6", 8'h45);
      wr(4'b0110, 32'h0099_AA00);
      wr(4'b1010, 32'h0000_BB00);
      check("R6 low fresh mid held", 32'(baud_div), 32'h99BB);

      // R9 / R10 with FIFO off (last fmt 00)
      check("R9 fifo off", 32'(fifo_en), 0);
      @(negedge clk); rx_done = 1'b1; rx_stop_bit = 1'b1;
      @(negedge clk); rx_done = 1'b0;
      check("R9 good stop", 32'(frame_err), 0);
      @(negedge clk); rx_done = 1'b1; rx_stop_bit = 1'b0;
      @(negedge clk); rx_done = 1'b0; rx_stop_bit = 1'b1;
      check("R9 bad stop sets", 32'(frame_err), 1);
      rd(2'd0, v); check("R7 status read", 32'(v), 1);
      @(negedge clk); rx_done = 1'b1; rx_stop_bit = 1'b1;
      @(negedge clk); rx_done = 1'b0;
      check("R9 sticky", 32'(frame_err), 1);
      wr(4'b0001, 32'h0000_0000);
      check("R10 clear", 32'(frame_err), 0);
      @(negedge clk); wr_be = 4'b0001; rx_done = 1'b1; rx_stop_bit = 1'b0;
      @(negedge clk); wr_be = '0; rx_done = 1'b0; rx_stop_bit = 1'b1;
      check("R10 set wins", 32'(frame_err), 1);
      wr(4'b0001, 32'h0000_00FF);
      check("R10 clear any data", 32'(frame_err), 0);

      // R11 FIFO mode
      wr(4'b1000, 32'h1000_0000);
      check("R11 fifo on", 32'(fifo_en), 1);
      @(negedge clk); rx_done = 1'b1; rx_stop_bit = 1'b0;
      @(negedge clk); rx_done = 1'b0; rx_stop_bit = 1'b1;
      check("R11 rx_done ignored", 32'(frame_err), 0);
      @(negedge clk); rx_head_adv = 1'b1; rx_head_ferr = 1'b1;
      @(negedge clk); rx_head_adv = 1'b0; rx_head_ferr = 1'b0;
      check("R11 head err", 32'(frame_err), 1);
      @(negedge clk); rx_head_ferr = 1'b0;
      @(negedge clk);
      check("R11 no adv holds", 32'(frame_err), 1);
      @(negedge clk); rx_head_adv = 1'b1;
      @(negedge clk); rx_head_adv = 1'b0;
      check("R11 head clean", 32'(frame_err), 0);
      @(negedge clk); rx_head_adv = 1'b1; rx_head_ferr = 1'b1;
      @(negedge clk); rx_head_adv = 1'b0; rx_head_ferr = 1'b0;
      wr(4'b0001, 32'h0);
      check("R10 clear fifo mode", 32'(frame_err), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule